// File: doc/BRIEF.md
# Tracking Error Fault Monitor

This block supervises two angle-tracking loops by looking at the signed angle error each loop produces. The error is expressed in output LSBs. For each loop, the block keeps a fault state with hysteresis. The fault is raised only when a large error lasts through a whole period of the excitation reference. It is dropped as soon as the error has shrunk well below the raising level. A single active-low flag reports the state of whichever loop the select line points at. Downstream logic treats a low flag as "the position word is not trustworthy".

Each channel is monitored all the time, whether or not it is selected. Moving the select line therefore shows the other channel's current state in the same cycle and disturbs neither monitor. After reset, both channels start in the fault state. The flag stays low until the loop error has come down close to zero, which marks the end of the settling after power-up. A loop that cannot keep up with its input, for example when the rotation rate exceeds the tracking limit, shows up as a persistent large error and is reported through the same path.

Top module: `track_fault_mon`

## Requirements
- R1: After reset, both channel monitors are in the fault state, so `fault_n` reads 0 whichever channel is selected. A value of 0 means the position data is invalid, and 1 means it is valid.
- R2: The error magnitude is the absolute value of the two's-complement input. The most negative code saturates to the largest positive magnitude (32767 at the default width), so it counts as a large error.
- R3: Only a magnitude strictly greater than `SET_LSB` (default 55) counts toward raising a fault. A magnitude of exactly 55 never raises one.
- R4: A fault is raised at the clock edge where `ref_tick` is seen for the second time, provided the magnitude has stayed above `SET_LSB` in every cycle from the first of those ticks onward. Any cycle at or below the threshold cancels the qualification.
- R5: A raised fault clears when the magnitude is strictly below `CLR_LSB` (default 45). At 44 it clears, and at 45 it does not.
- R6: A magnitude from `CLR_LSB` through `SET_LSB` inclusive leaves the channel state unchanged, whether it is currently faulted or clear.
- R7: `sel_a` = 1 shows channel A and `sel_a` = 0 shows channel B. The output follows a change of `sel_a` in the same cycle, with no clock edge needed.
- R8: Each channel keeps its own state and qualification progress. While a channel is deselected, it goes on raising and clearing faults, and switching the selection resets nothing.
- R9: Clearing does not wait for `ref_tick`. The flag goes high on the first clock edge at which the magnitude is below `CLR_LSB`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_a | input | ERR_W | Signed angle error of channel A, in LSBs |
| err_b | input | ERR_W | Signed angle error of channel B, in LSBs |
| sel_a | input | 1 | Channel select: 1 = A, 0 = B |
| ref_tick | input | 1 | One-cycle strobe, once per reference period |
| fault_n | output | 1 | Active-low fault flag of the selected channel |

## Verification
The error input is driven at the exact threshold edges: 44, 45, 55 and 56 on both sides of the hysteresis band. These values separate strict comparisons from inclusive ones and show that the band holds either state. Negative errors and the most negative code confirm that the magnitude is taken correctly and saturated. Large-error runs are given a single tick, two ticks, and two ticks with a dip in between, which separates a full-period persistence from an immediate or a cumulative one. Faults are also raised and cleared on the deselected channel, and the selection is then switched to it, which shows that the two monitors are independent and that the output mux is combinational.

// File: rtl/track_fault_pkg.sv
// Package: shared channel encoding and magnitude helper for the tracking
// error fault monitor. Assumes two's-complement error words.
package track_fault_pkg;

    // Channel index used for the per-channel state array.
    typedef enum logic {
        CH_B = 1'b0,
        CH_A = 1'b1
    } chan_e;

    // Absolute value of a 32-bit signed word, saturating the most negative code.
    function automatic logic [31:0] abs_sat32(input logic signed [31:0] v);
        logic [31:0] r;
        if (v == 32'sh8000_0000) r = 32'h7FFF_FFFF;
        else if (v < 0)          r = 32'(-v);
        else                     r = 32'(v);
        return r;
    endfunction

endpackage

// File: rtl/track_fault_mag.sv
// Module: converts a signed error word to an unsigned magnitude.
// Assumes ERR_W >= 2. The most negative code saturates to all ones.
module track_fault_mag #(
    parameter int ERR_W = 16,
    localparam int MAG_W = ERR_W - 1
) (
    input  logic [ERR_W-1:0] err_i,
    output logic [MAG_W-1:0] mag_o
);
    import track_fault_pkg::*;

    localparam logic [ERR_W-1:0] MOST_NEG = {1'b1, {(ERR_W-1){1'b0}}};

    logic [ERR_W-1:0] negated;

    // Two's-complement negation of the raw word.
    always_comb negated = (~err_i) + 1'b1;

    // Pick the positive form, saturating the one code that has none.
    always_comb begin
        if (err_i == MOST_NEG)  mag_o = {MAG_W{1'b1}};
        else if (err_i[ERR_W-1]) mag_o = negated[MAG_W-1:0];
        else                     mag_o = err_i[MAG_W-1:0];
    end

endmodule

// File: rtl/track_fault_chan.sv
// Module: per-channel fault state with hysteresis and reference-period
// persistence. Assumes ref_tick is a single-cycle strobe and that
// CLR_LSB < SET_LSB. Reset leaves the channel faulted.
module track_fault_chan #(
    parameter int MAG_W           = 15,
    parameter int SET_LSB         = 55,
    parameter int CLR_LSB         = 45,
    parameter int PERSIST_PERIODS = 1,
    localparam int CNT_W = (PERSIST_PERIODS < 2) ? 1 : $clog2(PERSIST_PERIODS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAG_W-1:0] mag_i,
    input  logic             tick_i,
    output logic             fault_o
);
    localparam logic [MAG_W-1:0] SET_LVL  = MAG_W'(SET_LSB);
    localparam logic [MAG_W-1:0] CLR_LVL  = MAG_W'(CLR_LSB);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERSIST_PERIODS);

    logic             over;
    logic             under;
    logic             fault_q;
    logic [CNT_W-1:0] qual_cnt;

    // Threshold comparisons, strict on both sides.
    always_comb begin
        over  = mag_i > SET_LVL;
        under = mag_i < CLR_LVL;
    end

    // Hysteresis state and tick-counted qualification of a large error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q  <= 1'b1;
            qual_cnt <= '0;
        end else if (fault_q) begin
            qual_cnt <= '0;
            if (under) fault_q <= 1'b0;
        end else if (!over) begin
            qual_cnt <= '0;
        end else if (tick_i) begin
            if (qual_cnt == CNT_LAST) begin
                fault_q  <= 1'b1;
                qual_cnt <= '0;
            end else begin
                qual_cnt <= qual_cnt + 1'b1;
            end
        end
    end

    assign fault_o = fault_q;

    AST_RESET_FAULTED: assert property (@(posedge clk) !rst_n |=> fault_q); // R1
    AST_SET_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_q) |-> ($past(tick_i) && $past(over))); // R4
    AST_CLEAR_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_q) |-> $past(under)); // R5
    AST_BAND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!over && !under) |=> $stable(fault_q)); // R6
    AST_QUAL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        qual_cnt <= CNT_LAST); // R4

endmodule

// File: rtl/track_fault_mon.sv
// Module: two-channel tracking error fault monitor. Both channels are
// monitored continuously. The active-low flag shows the selected channel
// through a combinational mux. Assumes synchronous inputs.
module track_fault_mon #(
    parameter int ERR_W           = 16,
    parameter int SET_LSB         = 55,
    parameter int CLR_LSB         = 45,
    parameter int PERSIST_PERIODS = 1,
    localparam int MAG_W = ERR_W - 1,
    localparam int NUM_CH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] err_a,
    input  logic [ERR_W-1:0] err_b,
    input  logic             sel_a,
    input  logic             ref_tick,
    output logic             fault_n
);
    import track_fault_pkg::*;

    logic [ERR_W-1:0] err_arr [NUM_CH];
    logic [MAG_W-1:0] mag_arr [NUM_CH];
    logic [NUM_CH-1:0] fault_arr;

    // Place the channel inputs in the array order given by chan_e.
    always_comb begin
        err_arr[CH_A] = err_a;
        err_arr[CH_B] = err_b;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        track_fault_mag #(
            .ERR_W(ERR_W)
        ) u_mag (
            .err_i(err_arr[ch]),
            .mag_o(mag_arr[ch])
        );

        track_fault_chan #(
            .MAG_W(MAG_W),
            .SET_LSB(SET_LSB),
            .CLR_LSB(CLR_LSB),
            .PERSIST_PERIODS(PERSIST_PERIODS)
        ) u_chan (
            .clk(clk),
            .rst_n(rst_n),
            .mag_i(mag_arr[ch]),
            .tick_i(ref_tick),
            .fault_o(fault_arr[ch])
        );
    end

    // Show the selected channel's state, inverted to active low.
    always_comb fault_n = ~fault_arr[sel_a ? CH_A : CH_B];

    AST_SWITCH_SHOWS_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(fault_arr) && (sel_a != $past(sel_a))) |->
        (fault_n == ~fault_arr[sel_a])); // R7

endmodule

// File: tb/track_fault_mon_bench.sv
module track_fault_mon_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] err_a = 16'd100;
    logic [15:0] err_b = 16'd100;
    logic        sel_a = 1'b1;
    logic        ref_tick = 1'b0;
    logic        fault_n;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t sb_q[$];

    always #2 clk = ~clk;

    track_fault_mon u_track_fault_mon (
        .clk(clk),
        .rst_n(rst_n),
        .err_a(err_a),
        .err_b(err_b),
        .sel_a(sel_a),
        .ref_tick(ref_tick),
        .fault_n(fault_n)
    );

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Drive one cycle of stimulus; expect fault_n after the next edge.
    task automatic cyc(input int ea, input int eb, input logic sa,
                       input logic tk, input logic exp, input string tag);
        @(negedge clk);
        err_a    = 16'(ea);
        err_b    = 16'(eb);
        sel_a    = sa;
        ref_tick = tk;
        sb_q.push_back('{exp, tag});
    endtask

    // Monitor: compare against the scoreboard just after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_chk++;
                if (fault_n !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: fault_n=%0b expected %0b", it.tag, fault_n, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state on both channels
        n_chk++;
        if (fault_n !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset chA: fault_n=%0b expected 0", fault_n);
        end
        sel_a = 1'b0;
        #1;
        n_chk++;
        if (fault_n !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset chB: fault_n=%0b expected 0", fault_n);
        end
        sel_a = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;

        cyc(100, 100, 1, 0, 0, "R1 held low while unsettled");
        cyc(0,   100, 1, 0, 1, "R9 clear without tick");
        cyc(0,   100, 0, 0, 0, "R7 view B still faulted");
        cyc(0,   44,  0, 0, 1, "R5 B clears at 44");
        cyc(45,  44,  1, 1, 1, "R6 band keeps clear");
        cyc(55,  0,   1, 1, 1, "R3 55 not over");
        cyc(55,  0,   1, 1, 1, "R3 55 across ticks");
        cyc(56,  0,   1, 0, 1, "R4 no tick yet");
        cyc(56,  0,   1, 1, 1, "R4 first tick arms");
        cyc(56,  0,   1, 0, 1, "R4 mid period");
        cyc(56,  0,   1, 1, 0, "R4 second tick sets");
        cyc(45,  0,   1, 0, 0, "R6 band keeps fault at 45");
        cyc(50,  0,   1, 1, 0, "R6 band keeps fault at 50");
        cyc(44,  0,   1, 0, 1, "R5 clears at 44");
        cyc(60,  0,   1, 1, 1, "R4 arm");
        cyc(55,  0,   1, 0, 1, "R4 dip cancels");
        cyc(60,  0,   1, 0, 1, "R4 over again");
        cyc(60,  0,   1, 1, 1, "R4 re-armed, no set");
        cyc(60,  0,   1, 1, 0, "R4 set after full period");
        cyc(-10, 0,   1, 0, 1, "R2 negative small clears");
        cyc(-56, 0,   1, 1, 1, "R2 negative arms");
        cyc(-56, 0,   1, 1, 0, "R2 negative over sets");
        cyc(-44, 0,   1, 0, 1, "R2 negative 44 clears");
        cyc(-32768, 0, 1, 1, 1, "R2 most negative arms");
        cyc(-32768, 0, 1, 1, 0, "R2 most negative saturates over");
        cyc(0,   0,   1, 0, 1, "R5 clear");
        cyc(100, 0,   0, 1, 1, "R8 A arms while hidden");
        cyc(100, 0,   0, 1, 1, "R8 A sets while hidden");
        cyc(100, 0,   1, 0, 0, "R7 switch shows A fault");
        cyc(0,   70,  1, 1, 1, "R8 B arms while hidden");
        cyc(0,   70,  0, 1, 0, "R8 B sets across switch");
        cyc(0,   0,   0, 0, 1, "R5 B clears");
        cyc(0,   0,   1, 0, 1, "R7 A clear view");

        @(negedge clk);
        @(negedge clk);
        n_chk++;
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: pending=%0d expected 0", sb_q.size());
        end
        report();
        $finish;
    end

endmodule